// File: doc/BRIEF.md
# Page Permission Checker with Identity Mapping

This block sits in a processor's address-generation stage and decides, in the same cycle, whether a memory request may proceed. Addresses are never translated: the address presented to memory is the request address, bit for bit. The block keeps a small table of access rights for a window of consecutive 4 KiB pages. When protection is on, each request is checked against the rights of its page.

An allowed request drives the memory-enable output. A refused request holds memory-enable low, so a forbidden store never reaches memory. It also raises a trap and records the data address, the instruction address and whether the request was a store. The record is sticky: it keeps the first fault until software clears it. Protection starts switched off after reset. Software turns it on or off, and rewrites individual page rights, through a small write-only configuration port. There is nothing to reload when the running thread changes.

Top module: `pgchk_top`

## Requirements
- R1: After reset, protection is off (`prot_en_o`=0), no fault is recorded (`fault_valid_o`=0), and every table entry holds code 11 (read/write).
- R2: `mem_addr_o` always equals `acc_addr_i`, whatever the request type or outcome.
- R3: While protection is off, every valid request is allowed: `mem_en_o`=1 and `trap_o`=0, whatever the table holds.
- R4: The 2-bit rights code is 00 = no access, 01 = read-only, 11 = read/write, and 10 behaves as no access. A load (`acc_write_i`=0) is refused only on codes 00 and 10.
- R5: A store (`acc_write_i`=1) is refused on codes 00, 10 and 01, and allowed on code 11.
- R6: The table covers PAGES pages starting at WIN_BASE. Page index = (address[31:12] − WIN_BASE[31:12]). A request whose index is not below PAGES is always allowed.
- R7: In the cycle of a valid request, a refused request gives `trap_o`=1 and `mem_en_o`=0, and an allowed request gives `trap_o`=0 and `mem_en_o`=1. With `acc_valid_i`=0 both outputs are 0 and nothing is recorded.
- R8: At the clock edge of a trap, if no fault is held, the block records the data address, the instruction address and the store flag. These appear on the `fault_*` outputs from the next cycle.
- R9: A held fault is kept unchanged through later traps. It is cleared only by a configuration write to address PAGES+1 with data bit 0 = 1. A write with bit 0 = 0 has no effect. If a trap arrives in the same cycle as a clear, the new fault is recorded.
- R10: Configuration map: addresses 0 to PAGES−1 write the 2-bit code of that page from `cfg_wdata_i[1:0]`. Address PAGES writes the protection enable from bit 0.
- R11: A table or enable write changes only the checks made from the following cycle onward. A request in the same cycle as the write is judged on the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration register address |
| cfg_wdata_i | input | 2 | Configuration write data |
| acc_valid_i | input | 1 | Memory request present |
| acc_write_i | input | 1 | Request is a store |
| acc_addr_i | input | 32 | Request data address |
| acc_pc_i | input | 32 | Address of the issuing instruction |
| mem_addr_o | output | 32 | Address to memory (identical to request) |
| mem_en_o | output | 1 | Request allowed to reach memory |
| trap_o | output | 1 | Permission violation this cycle |
| prot_en_o | output | 1 | Current protection enable |
| fault_valid_o | output | 1 | Sticky fault held |
| fault_addr_o | output | 32 | Recorded data address |
| fault_pc_o | output | 32 | Recorded instruction address |
| fault_write_o | output | 1 | Recorded request was a store |

## Verification
The assertions check several rules on every cycle:
- a trap and a memory enable never occur together;
- nothing traps while protection is off or outside the window;
- a held fault stays frozen until it is cleared;
- a fresh trap is recorded with the instruction address of that cycle.

Other rules depend on the table contents, so only the bench scenarios can show them:
- the mapping from rights code to the load and store outcome, including the reserved code 10;
- the one-cycle delay before a configuration write takes effect;
- the ignored clear with data 0;
- a clear and a trap arriving in the same cycle.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  // Whether a rights code permits a load or a store
  function automatic logic perm_allows(input logic [1:0] code, input logic is_store);
    case (code)
      PERM_RW: perm_allows = 1'b1;
      PERM_RO: perm_allows = !is_store;
      default: perm_allows = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pgchk_table.sv
module pgchk_table #(
  parameter int PAGES = 64,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_code,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_code
);
  import pgchk_pkg::*;

  logic [1:0] code_q [PAGES];

  for (genvar g = 0; g < PAGES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[g] <= PERM_RW;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        code_q[g] <= wr_code;
      end
    end
  end

  assign rd_code = code_q[rd_idx];

endmodule

// File: rtl/pgchk_fault.sv
module pgchk_fault #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              write_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              write_o
);

  logic capture;
  assign capture = trap_i && (!valid_o || clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      pc_o    <= '0;
      write_o <= 1'b0;
    end else begin
      if (capture) begin
        valid_o <= 1'b1;
        addr_o  <= addr_i;
        pc_o    <= pc_i;
        write_o <= write_i;
      end else if (clr_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  // R9: a held fault with no clear stays unchanged
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !clr_i |=> valid_o && $stable(pc_o) && $stable(addr_o) && $stable(write_o));

  // R8: first trap is recorded with its instruction address
  a_r8_capture_pc: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && !valid_o |=> valid_o && pc_o == $past(pc_i) && addr_o == $past(addr_i));

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top #(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_SHIFT = 12,
  parameter int          PAGES      = 64,
  parameter logic [31:0] WIN_BASE   = 32'h0004_0000,
  localparam int         IDX_W      = $clog2(PAGES),
  localparam int         CFG_AW     = IDX_W + 1,
  localparam int         PN_W       = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [1:0]        cfg_wdata_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [ADDR_W-1:0] acc_pc_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_en_o,
  output logic              trap_o,
  output logic              prot_en_o,
  output logic              fault_valid_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [ADDR_W-1:0] fault_pc_o,
  output logic              fault_write_o
);
  import pgchk_pkg::*;

  localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(PAGES);
  localparam logic [CFG_AW-1:0] CLR_ADDR  = CFG_AW'(PAGES + 1);

  // Page offset from the window base; the window is the offsets below PAGES
  function automatic logic [PN_W-1:0] page_offset(input logic [ADDR_W-1:0] a);
    page_offset = a[ADDR_W-1:PAGE_SHIFT] - WIN_BASE[ADDR_W-1:PAGE_SHIFT];
  endfunction

  // Named events for assertions
  logic             wr_page, wr_ctrl, wr_clear;
  logic [PN_W-1:0]  pg_off;
  logic             in_window;
  logic [1:0]       page_code;
  logic             refused;
  logic             en_q;

  assign wr_page  = cfg_we_i && !cfg_addr_i[IDX_W];
  assign wr_ctrl  = cfg_we_i && cfg_addr_i == CTRL_ADDR;
  assign wr_clear = cfg_we_i && cfg_addr_i == CLR_ADDR && cfg_wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (wr_ctrl) en_q <= cfg_wdata_i[0];
  end

  pgchk_table #(.PAGES(PAGES)) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_page),
    .wr_idx  (cfg_addr_i[IDX_W-1:0]),
    .wr_code (cfg_wdata_i),
    .rd_idx  (pg_off[IDX_W-1:0]),
    .rd_code (page_code)
  );

  assign pg_off    = page_offset(acc_addr_i);
  assign in_window = pg_off < PN_W'(PAGES);
  assign refused   = en_q && in_window && !perm_allows(page_code, acc_write_i);

  assign mem_addr_o = acc_addr_i;
  assign trap_o     = acc_valid_i && refused;
  assign mem_en_o   = acc_valid_i && !refused;
  assign prot_en_o  = en_q;

  pgchk_fault #(.ADDR_W(ADDR_W)) fault_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trap_i  (trap_o),
    .clr_i   (wr_clear),
    .addr_i  (acc_addr_i),
    .pc_i    (acc_pc_i),
    .write_i (acc_write_i),
    .valid_o (fault_valid_o),
    .addr_o  (fault_addr_o),
    .pc_o    (fault_pc_o),
    .write_o (fault_write_o)
  );

  // R7: a trapped request never reaches memory
  a_r7_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !mem_en_o);

  // R3: no trap while protection is off
  a_r3_off_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en_o |-> !trap_o);

  // R6: no trap outside the window
  a_r6_outside_free: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && !in_window |-> mem_en_o && !trap_o);

  // R11: enable changes only through a control write in the previous cycle
  a_r11_en_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(prot_en_o));

endmodule

// File: tb/pgchk_top_tb_top.sv
module pgchk_top_tb_top;

  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam int PGS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [1:0]  cfg_wdata = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0, acc_pc = '0;
  logic [31:0] mem_addr, fault_addr, fault_pc;
  logic        mem_en, trap, prot_en, fault_valid, fault_write;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgchk_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .acc_pc_i(acc_pc), .mem_addr_o(mem_addr),
    .mem_en_o(mem_en), .trap_o(trap), .prot_en_o(prot_en),
    .fault_valid_o(fault_valid), .fault_addr_o(fault_addr),
    .fault_pc_o(fault_pc), .fault_write_o(fault_write)
  );

  // Vector: {page[5:0], is_store, expect_refused}; pages 0..3 hold 00,01,10,11
  localparam logic [7:0] VEC [11] = '{
    {6'd0, 1'b0, 1'b1}, {6'd0, 1'b1, 1'b1},
    {6'd1, 1'b0, 1'b0}, {6'd1, 1'b1, 1'b1},
    {6'd2, 1'b0, 1'b1}, {6'd2, 1'b1, 1'b1},
    {6'd3, 1'b0, 1'b0}, {6'd3, 1'b1, 1'b0},
    {6'd4, 1'b0, 1'b0}, {6'd4, 1'b1, 1'b0},
    {6'd63, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] page_addr(input int p, input int ofs);
    return BASE + 32'(p) * 32'h1000 + 32'(ofs);
  endfunction

  task automatic cfg_write(input logic [6:0] a, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive a request at a negedge, check outputs mid-cycle, hold through posedge
  task automatic access(input logic [31:0] a, input logic wr, input logic [31:0] pc,
                        input logic exp_ref, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_pc = pc;
    #5;
    check(req, {31'b0, trap}, {31'b0, exp_ref});
    check(req, {31'b0, mem_en}, {31'b0, !exp_ref});
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 prot_en", {31'b0, prot_en}, 32'd0);
    check("R1 fault_valid", {31'b0, fault_valid}, 32'd0);

    // Program pages 0..3 while protection off
    for (int p = 0; p < 4; p++) cfg_write(7'(p), 2'(p));
    // R3: off, so a store to a no-access page passes
    access(page_addr(0, 8), 1'b1, 32'h100, 1'b0, "R3 off allows");
    check("R3 no capture", {31'b0, fault_valid}, 32'd0);

    cfg_write(7'd64, 2'b01);
    check("R10 enable set", {31'b0, prot_en}, 32'd1);
    // R1: untouched page holds read/write
    access(page_addr(9, 0), 1'b1, 32'h104, 1'b0, "R1 default RW");

    // R4 R5 vector walk
    for (int i = 0; i < 11; i++)
      access(page_addr(int'(VEC[i][7:2]), 16), VEC[i][1], 32'h200 + 32'(i),
             VEC[i][0], VEC[i][1] ? "R5 store rule" : "R4 load rule");

    // Clear fault, R9
    cfg_write(7'd65, 2'b01);
    check("R9 clear", {31'b0, fault_valid}, 32'd0);

    // R2 passthrough
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = page_addr(0, 32'h0abc); #5;
    check("R2 addr pass", mem_addr, page_addr(0, 32'h0abc));
    @(negedge clk); acc_valid = 1'b0;

    // R6 outside window both sides
    access(BASE - 32'h1000, 1'b1, 32'h300, 1'b0, "R6 below window");
    access(page_addr(PGS, 0), 1'b1, 32'h304, 1'b0, "R6 above window");

    // R7 idle request on refused page
    cfg_write(7'd65, 2'b01);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_addr = page_addr(0, 0); #5;
    check("R7 idle trap", {31'b0, trap}, 32'd0);
    check("R7 idle mem_en", {31'b0, mem_en}, 32'd0);
    @(negedge clk);
    check("R7 idle no capture", {31'b0, fault_valid}, 32'd0);

    // R8 capture
    access(page_addr(1, 32'h44), 1'b1, 32'hA000_0010, 1'b1, "R8 trap");
    check("R8 valid", {31'b0, fault_valid}, 32'd1);
    check("R8 addr", fault_addr, page_addr(1, 32'h44));
    check("R8 pc", fault_pc, 32'hA000_0010);
    check("R8 write", {31'b0, fault_write}, 32'd1);
    // R9 second fault ignored
    access(page_addr(0, 4), 1'b0, 32'hB000_0020, 1'b1, "R9 second trap");
    check("R9 keeps first pc", fault_pc, 32'hA000_0010);
    check("R9 keeps first write", {31'b0, fault_write}, 32'd1);
    // R9 write of 0 ignored
    cfg_write(7'd65, 2'b00);
    check("R9 zero write ignored", {31'b0, fault_valid}, 32'd1);
    // R9 clear with simultaneous trap
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd65; cfg_wdata = 2'b01;
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = page_addr(2, 0); acc_pc = 32'hC000_0030;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    check("R9 clear+trap valid", {31'b0, fault_valid}, 32'd1);
    check("R9 clear+trap pc", fault_pc, 32'hC000_0030);
    check("R9 clear+trap write", {31'b0, fault_write}, 32'd0);
    cfg_write(7'd65, 2'b01);
    check("R9 cleared", {31'b0, fault_valid}, 32'd0);

    // R11 table write: same cycle uses old, next uses new
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd5; cfg_wdata = 2'b00;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = page_addr(5, 0); #5;
    check("R11 old rights", {31'b0, trap}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; #5;
    check("R11 new rights", {31'b0, trap}, 32'd1);
    check("R11 new blocks", {31'b0, mem_en}, 32'd0);
    @(negedge clk); acc_valid = 1'b0;

    // R11 disable: same cycle still protected, next cycle free
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd64; cfg_wdata = 2'b00;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = page_addr(0, 0); #5;
    check("R11 still enabled", {31'b0, trap}, 32'd1);
    @(negedge clk);
    cfg_we = 1'b0; #5;
    check("R3 disabled at run time", {31'b0, mem_en}, 32'd1);
    check("R10 enable cleared", {31'b0, prot_en}, 32'd0);
    @(negedge clk); acc_valid = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule